// File: doc/BRIEF.md
# Generator Cool-Down Stop Sequencer

This block stops a standby generator on its own once utility power comes back. A mains-present rising edge arms it, but only while automatic mode is selected and the engine reports running. The block then counts an off-load cool-down period in millisecond ticks. At the end of the cool-down it opens a short strobe window. If the engine is still running in that window, a stop latch is set, and the latch drives the stop solenoid.

Once set, the latch holds the solenoid for a programmable number of ticks, whatever the mains, mode and engine inputs do, so that the engine can reach a dead stop. After the hold time, the latch stays set as long as the engine is still running, and a status flag reports that overrun. The latch clears one cycle after the hold time has expired and the engine has stopped. A pulse that marks a manual-to-automatic mode change clears both the latch and any cool-down in progress.

Top module: `gen_cooldown_stop`

## Requirements
- R1: A cool-down starts only in a cycle where mains_ok is 1 after being 0 in the previous cycle, with auto_mode = 1 and eng_run = 1 in that same cycle. cool_active rises on the following clock edge.
- R2: cool_active stays 1 for exactly COOL_TICKS ms_tick pulses, counted from its rise.
- R3: When the cool-down ends, a strobe window lasts STROBE_TICKS ticks. stop_drive is set one cycle after a strobe cycle in which eng_run = 1 and auto_mode = 1. If the engine has already stopped, stop_drive stays 0.
- R4: Once stop_drive is set, the hold time is the number of ms_tick pulses received after the set. The hold length is the value of hold_ticks sampled in the set cycle.
- R5: While the hold time has not expired, stop_drive stays 1 regardless of mains_ok, auto_mode and eng_run.
- R6: One cycle after the hold time has expired with eng_run = 0, stop_drive returns to 0.
- R7: If mains_ok falls or auto_mode falls during the cool-down, cool_active drops on the next edge and no stop follows.
- R8: stop_overrun is 1 exactly while stop_drive is 1, the hold time has expired and eng_run is still 1.
- R9: A hold_ticks value of 0 selects HOLD_DEFAULT ticks. The default value of HOLD_DEFAULT is 13000, which is 13 s.
- R10: auto_entry = 1 clears stop_drive and cool_active on the next edge. This applies during the hold as well.
- R11: While reset is applied, and just after it is released, stop_drive, cool_active and stop_overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | Automatic mode selected |
| mains_ok | input | 1 | Utility supply present |
| eng_run | input | 1 | Engine running |
| auto_entry | input | 1 | One-cycle pulse on a manual-to-automatic change |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| hold_ticks | input | HOLD_W | Solenoid hold time in ticks (0 selects the default) |
| stop_drive | output | 1 | Stop-solenoid drive |
| cool_active | output | 1 | Cool-down in progress |
| stop_overrun | output | 1 | Hold time expired while the engine is still running |

## Verification
The main sequence runs with the engine stopping partway through the hold, which separates the fixed hold time from the wait for the engine. A second run leaves the engine running past the hold and uses a zero hold value; this exposes the overrun flag and the default length. Four patterns must never produce a stop: mains dropping mid cool-down, the engine dying before the strobe, manual mode and an idle engine at the mains edge. A mode-entry pulse during the hold shows that it overrides the forced hold. Tick counts are compared exactly, so an off-by-one error in any counter is detected.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  typedef enum logic [1:0] {
    CD_IDLE   = 2'd0,
    CD_COOL   = 2'd1,
    CD_STROBE = 2'd2
  } cd_state_t;
endpackage

// File: rtl/gcs_rst_sync.sv
module gcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gcs_tick_counter.sv
module gcs_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/gcs_cooldown.sv
module gcs_cooldown
  import gcs_pkg::*;
#(
  parameter int COOL_TICKS   = 30000,
  parameter int STROBE_TICKS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic abort,
  input  logic ms_tick,
  output logic strobe,
  output logic cool_active
);
  localparam int MAXT = (COOL_TICKS > STROBE_TICKS) ? COOL_TICKS : STROBE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  cd_state_t    state_q, state_d;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_inc;

  gcs_tick_counter #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      CD_IDLE: begin
        cnt_clr = 1'b1;
        if (arm && !abort) state_d = CD_COOL;
      end
      CD_COOL: begin
        if (abort) begin
          state_d = CD_IDLE;
          cnt_clr = 1'b1;
        end else if (ms_tick) begin
          if (cnt == CW'(COOL_TICKS - 1)) begin
            state_d = CD_STROBE;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      CD_STROBE: begin
        if (abort) begin
          state_d = CD_IDLE;
          cnt_clr = 1'b1;
        end else if (ms_tick) begin
          if (cnt == CW'(STROBE_TICKS - 1)) begin
            state_d = CD_IDLE;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      default: begin
        state_d = CD_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CD_IDLE;
    else        state_q <= state_d;
  end

  assign strobe      = (state_q == CD_STROBE);
  assign cool_active = (state_q == CD_COOL);
endmodule

// File: rtl/gcs_stop_latch.sv
module gcs_stop_latch #(
  parameter int HOLD_W       = 16,
  parameter int HOLD_DEFAULT = 13000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_req,
  input  logic              force_clr,
  input  logic              eng_run,
  input  logic              ms_tick,
  input  logic [HOLD_W-1:0] hold_ticks,
  output logic              latched,
  output logic              hold_done
);
  localparam logic [HOLD_W-1:0] DEF_HOLD = HOLD_W'(HOLD_DEFAULT);

  logic              latched_d;
  logic [HOLD_W-1:0] target_q, target_d;
  logic [HOLD_W-1:0] cnt;
  logic              cnt_clr, cnt_inc, setting;

  gcs_tick_counter #(.W(HOLD_W)) u_hold_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  assign hold_done = latched && (cnt >= target_q);
  assign setting   = !force_clr && !latched && set_req;

  always_comb begin
    latched_d = latched;
    target_d  = target_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    if (force_clr) begin
      latched_d = 1'b0;
      cnt_clr   = 1'b1;
    end else if (setting) begin
      latched_d = 1'b1;
      target_d  = (hold_ticks == '0) ? DEF_HOLD : hold_ticks;
      cnt_clr   = 1'b1;
    end else if (latched) begin
      if (hold_done) begin
        if (!eng_run) begin
          latched_d = 1'b0;
          cnt_clr   = 1'b1;
        end
      end else if (ms_tick) begin
        cnt_inc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= 1'b0;
      target_q <= '0;
    end else begin
      latched  <= latched_d;
      target_q <= target_d;
    end
  end
endmodule

// File: rtl/gen_cooldown_stop.sv
module gen_cooldown_stop #(
  parameter int COOL_TICKS   = 30000,
  parameter int STROBE_TICKS = 11,
  parameter int HOLD_W       = 16,
  parameter int HOLD_DEFAULT = 13000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_mode,
  input  logic              mains_ok,
  input  logic              eng_run,
  input  logic              auto_entry,
  input  logic              ms_tick,
  input  logic [HOLD_W-1:0] hold_ticks,
  output logic              stop_drive,
  output logic              cool_active,
  output logic              stop_overrun
);
  logic rst_i_n;
  logic mains_q;
  logic arm, abort, strobe, hold_done;

  gcs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mains_q <= 1'b1;
    else          mains_q <= mains_ok;
  end

  assign arm   = mains_ok && !mains_q && auto_mode && eng_run;
  assign abort = !mains_ok || !auto_mode || auto_entry;

  gcs_cooldown #(
    .COOL_TICKS   (COOL_TICKS),
    .STROBE_TICKS (STROBE_TICKS)
  ) u_cool (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .arm         (arm),
    .abort       (abort),
    .ms_tick     (ms_tick),
    .strobe      (strobe),
    .cool_active (cool_active)
  );

  gcs_stop_latch #(
    .HOLD_W       (HOLD_W),
    .HOLD_DEFAULT (HOLD_DEFAULT)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .set_req    (strobe && eng_run && auto_mode),
    .force_clr  (auto_entry),
    .eng_run    (eng_run),
    .ms_tick    (ms_tick),
    .hold_ticks (hold_ticks),
    .latched    (stop_drive),
    .hold_done  (hold_done)
  );

  assign stop_overrun = hold_done && eng_run;
endmodule

// File: rtl/gen_cooldown_stop_checker.sv
module gen_cooldown_stop_checker (
  input logic clk,
  input logic rst_n,
  input logic auto_mode,
  input logic mains_ok,
  input logic eng_run,
  input logic auto_entry,
  input logic strobe,
  input logic hold_done,
  input logic stop_drive,
  input logic cool_active,
  input logic stop_overrun
);
  a_r1_arm_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cool_active) |-> $past(auto_mode && eng_run && mains_ok));

  a_r3_set_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_drive) |-> $past(strobe && eng_run && auto_mode));

  a_r5_hold_forced: assert property (@(posedge clk) disable iff (!rst_n)
    stop_drive && !hold_done && !auto_entry |=> stop_drive);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_drive && hold_done && !eng_run && !auto_entry |=> !stop_drive);

  a_r7_mains_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cool_active && !mains_ok |=> !cool_active);

  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    stop_overrun |-> stop_drive && eng_run);

  a_r10_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    auto_entry |=> !stop_drive && !cool_active);
endmodule

bind gen_cooldown_stop gen_cooldown_stop_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_i_n),
  .auto_mode    (auto_mode),
  .mains_ok     (mains_ok),
  .eng_run      (eng_run),
  .auto_entry   (auto_entry),
  .strobe       (strobe),
  .hold_done    (hold_done),
  .stop_drive   (stop_drive),
  .cool_active  (cool_active),
  .stop_overrun (stop_overrun)
);

// File: tb/gen_cooldown_stop_bench.sv
module gen_cooldown_stop_bench;
  localparam int COOL   = 20;
  localparam int STRB   = 3;
  localparam int HW     = 16;
  localparam int HDEF   = 10;

  logic clk = 1'b0;
  logic rst_n, auto_mode, mains_ok, eng_run, auto_entry, ms_tick;
  logic [HW-1:0] hold_ticks;
  logic stop_drive, cool_active, stop_overrun;
  int checks = 0, errors = 0, cyc = 0;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  gen_cooldown_stop #(
    .COOL_TICKS(COOL), .STROBE_TICKS(STRB), .HOLD_W(HW), .HOLD_DEFAULT(HDEF)
  ) u_gen_cooldown_stop (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .mains_ok(mains_ok),
    .eng_run(eng_run), .auto_entry(auto_entry), .ms_tick(ms_tick),
    .hold_ticks(hold_ticks), .stop_drive(stop_drive),
    .cool_active(cool_active), .stop_overrun(stop_overrun)
  );

  always @(negedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    ms_tick <= (tdiv == 3);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic mains_rise();
    mains_ok = 1'b0; step(); step();
    mains_ok = 1'b1; step();
  endtask

  // counts ticks consumed while cool_active is 1
  task automatic count_cool(output int n);
    n = 0;
    for (int i = 0; i < 1000 && cool_active; i++) begin
      if (ms_tick) n++;
      step();
    end
  endtask

  task automatic wait_stop(output bit seen);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (stop_drive) seen = 1; else step();
    end
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < 4 * n; i++) step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; auto_mode = 1'b1; mains_ok = 1'b1; eng_run = 1'b0;
    auto_entry = 1'b0; hold_ticks = '0;
    step(); step();
    chk(!stop_drive && !cool_active && !stop_overrun, "R11 outputs in reset",
        {stop_drive, cool_active, stop_overrun}, 0);
    rst_n = 1'b1; step(); step(); step();
    chk(!stop_drive && !cool_active && !stop_overrun, "R11 outputs after release",
        {stop_drive, cool_active, stop_overrun}, 0);
  endtask

  task automatic t_normal();
    int n; bit seen;
    auto_mode = 1; eng_run = 1; hold_ticks = 6;
    mains_rise();
    chk(cool_active, "R1 cool-down starts", cool_active, 1);
    count_cool(n);
    chk(n == COOL, "R2 cool-down length", n, COOL);
    wait_stop(seen);
    chk(seen, "R3 stop set with engine running", seen, 1);
    n = 0;
    for (int i = 0; i < 500 && stop_drive; i++) begin
      if (ms_tick) begin
        n++;
        if (n == 2) begin eng_run = 0; mains_ok = 0; auto_mode = 0; end
      end
      if (n == 3) chk(stop_drive, "R5 held despite inputs", stop_drive, 1);
      step();
    end
    chk(n == 6, "R4 hold ticks programmed", n, 6);
    chk(!stop_drive, "R6 released after hold and stop", stop_drive, 0);
    auto_mode = 1;
  endtask

  task automatic t_overrun();
    int n; bit seen;
    auto_mode = 1; eng_run = 1; hold_ticks = 0;
    mains_rise();
    count_cool(n);
    wait_stop(seen);
    n = 0;
    for (int i = 0; i < 500 && stop_drive && !stop_overrun; i++) begin
      if (ms_tick) n++;
      step();
    end
    chk(n == HDEF, "R9 default hold length", n, HDEF);
    chk(stop_overrun && stop_drive, "R8 overrun flagged", stop_overrun, 1);
    idle_ticks(3);
    chk(stop_drive && stop_overrun, "R8 drive kept while running", stop_drive, 1);
    eng_run = 0; step();
    chk(!stop_drive && !stop_overrun, "R6 release on engine stop", stop_drive, 0);
  endtask

  task automatic t_mains_lost();
    auto_mode = 1; eng_run = 1;
    mains_rise();
    idle_ticks(5);
    mains_ok = 0; step();
    chk(!cool_active, "R7 abandon on mains loss", cool_active, 1'b0);
    idle_ticks(COOL + STRB + 2);
    chk(!stop_drive, "R7 no stop after abandon", stop_drive, 0);
  endtask

  task automatic t_auto_lost();
    auto_mode = 1; eng_run = 1;
    mains_rise();
    idle_ticks(4);
    auto_mode = 0; step();
    chk(!cool_active, "R7 abandon on auto loss", cool_active, 0);
    auto_mode = 1;
    idle_ticks(COOL + STRB + 2);
    chk(!stop_drive, "R7 no stop after auto loss", stop_drive, 0);
  endtask

  task automatic t_engine_died();
    int n;
    auto_mode = 1; eng_run = 1;
    mains_rise();
    idle_ticks(4);
    eng_run = 0;
    count_cool(n);
    idle_ticks(STRB + 2);
    chk(!stop_drive, "R3 no strobe when engine stopped", stop_drive, 0);
  endtask

  task automatic t_not_armed();
    auto_mode = 0; eng_run = 1;
    mains_rise();
    chk(!cool_active, "R1 manual mode ignores mains", cool_active, 0);
    auto_mode = 1; eng_run = 0;
    mains_rise();
    chk(!cool_active, "R1 idle engine ignores mains", cool_active, 0);
    idle_ticks(COOL + STRB + 2);
    chk(!stop_drive, "R1 no stop when not armed", stop_drive, 0);
  endtask

  task automatic t_entry_clear();
    int n; bit seen;
    auto_mode = 1; eng_run = 1; hold_ticks = 8;
    mains_rise();
    count_cool(n);
    wait_stop(seen);
    idle_ticks(2);
    auto_entry = 1; step(); auto_entry = 0;
    chk(!stop_drive, "R10 entry pulse clears hold", stop_drive, 0);
    mains_rise();
    idle_ticks(2);
    auto_entry = 1; step(); auto_entry = 0;
    chk(!cool_active, "R10 entry pulse clears cool-down", cool_active, 0);
    eng_run = 0;
  endtask

  initial begin
    t_reset();
    t_normal();
    t_overrun();
    t_mains_lost();
    t_auto_lost();
    t_engine_died();
    t_not_armed();
    t_entry_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule